// File: doc/BRIEF.md
# Multi-Phase Error Sampling Unit

This block watches the one-bit result of a voltage comparator and records the error direction at four equally spaced instants inside each period of a slow base clock. A regulator loop then sees the error four times per period without raising its clock rate. Each recorded direction goes to one of two up/down buses, a coarse one or a fine one, chosen by a mode bit, together with a matching one-cycle strobe. The strobe tells the following shift-register stage when to step.

Everything runs on a single fast clock `clk`. The base clock and the four phase clocks arrive as single-cycle ticks in that clock domain. Once the loop reports regulation, the three extra phases are switched off. The single remaining sample is then taken once per base period, on the base tick. A two-bit phase-switch control also allows a half-rate pattern that drops the odd phases.

Top module: `mp_err_sampler`

## Requirements
- R1: While `rst_n` is low, every output (`perr`, `c_ud`, `f_ud`, `c_stb`, `f_stb`) is zero.
- R2: `cmp_in` passes through a two-flop synchroniser. A phase that fires at clock edge k stores the `cmp_in` value that was present at edge k-2.
- R3: Bit N of `perr` changes only at an edge where phase N fires. At every other edge the bit holds its value.
- R4: `mode_in` and `psw_in` are captured only at edges where `base_tick` is high. The captured values govern the edges that follow, so a mode change never cuts a phase short.
- R5: The unit is regulated when the captured mode is 0 and captured `psw` bit 0 is 1. While regulated, phases 1 to 3 never fire, and their `perr`, bus and strobe bits hold.
- R6: While regulated, phase 0 fires on `base_tick`, and `ph_tick[0]` has no effect.
- R7: While not regulated and captured `psw` bit 1 is 1, the odd phases (1 and 3) are disabled and their bits hold. Phases 0 and 2 keep firing.
- R8: With captured mode 1, a phase N that fires at an edge sets `c_stb[N]` high for exactly the following cycle and loads `c_ud[N]` with the sample. The fine outputs are left unchanged.
- R9: With captured mode 0, a phase N that fires at an edge sets `f_stb[N]` high for exactly the following cycle and loads `f_ud[N]` with the sample. The coarse outputs are left unchanged.
- R10: The coarse strobes and the fine strobes are never high in the same cycle. Whenever `c_stb[N]` or `f_stb[N]` is high, the matching bus bit equals `perr[N]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | One-cycle pulse marking each base-clock rising edge |
| ph_tick | input | NPH | One-cycle pulses marking each phase-clock rising edge |
| cmp_in | input | 1 | Comparator result, asynchronous |
| mode_in | input | 1 | 1 selects coarse (large error), 0 selects fine |
| psw_in | input | 2 | Phase switch: bit 0 requests single-phase, bit 1 drops odd phases |
| perr | output | NPH | Per-phase error direction word |
| c_ud | output | NPH | Coarse up/down bus |
| f_ud | output | NPH | Fine up/down bus |
| c_stb | output | NPH | Coarse step strobes |
| f_stb | output | NPH | Fine step strobes |

## Verification
Some properties hold on every cycle, and the assertions check those: the two strobe groups never overlap, a strobe always matches the bus bit and the error bit it belongs to, the captured mode changes only at base ticks, phases 1 to 3 stay silent while regulated, and an error bit holds while its phase tick is absent. The bench scenarios are needed for the behaviour that depends on data and history: the two-cycle comparator latency, phase 0 moving from its phase tick onto the base tick, the odd-phase drop, and mode changes arriving in the middle of a period and waiting for the next base tick.

// File: rtl/mp_err_sampler.sv
module mp_err_sampler #(
  parameter int NPH = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           base_tick,
  input  logic [NPH-1:0] ph_tick,
  input  logic           cmp_in,
  input  logic           mode_in,
  input  logic [1:0]     psw_in,
  output logic [NPH-1:0] perr,
  output logic [NPH-1:0] c_ud,
  output logic [NPH-1:0] f_ud,
  output logic [NPH-1:0] c_stb,
  output logic [NPH-1:0] f_stb
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   mode_q;
  logic [1:0]             psw_q;
  logic [NPH-1:0]         fire;
  logic                   regulated;
  logic                   err_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], cmp_in};
  end

  assign err_bit   = sync_q[SYNC_STAGES-1];
  assign regulated = !mode_q && psw_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      psw_q  <= 2'b00;
    end else if (base_tick) begin
      mode_q <= mode_in;
      psw_q  <= psw_in;
    end
  end

  for (genvar n = 0; n < NPH; n++) begin : g_ph
    if (n == 0) begin : g_lead
      assign fire[n] = regulated ? base_tick : ph_tick[n];
    end else if (n % 2 == 1) begin : g_odd
      assign fire[n] = ph_tick[n] && !regulated && !psw_q[1];
    end else begin : g_even
      assign fire[n] = ph_tick[n] && !regulated;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        perr[n]  <= 1'b0;
        c_ud[n]  <= 1'b0;
        f_ud[n]  <= 1'b0;
        c_stb[n] <= 1'b0;
        f_stb[n] <= 1'b0;
      end else begin
        c_stb[n] <= fire[n] && mode_q;
        f_stb[n] <= fire[n] && !mode_q;
        if (fire[n]) begin
          perr[n] <= err_bit;
          if (mode_q) c_ud[n] <= err_bit;
          else        f_ud[n] <= err_bit;
        end
      end
    end
  end

endmodule

module mp_err_sampler_chk #(
  parameter int NPH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           base_tick,
  input logic [NPH-1:0] ph_tick,
  input logic           mode_q,
  input logic [1:0]     psw_q,
  input logic [NPH-1:0] perr,
  input logic [NPH-1:0] c_ud,
  input logic [NPH-1:0] f_ud,
  input logic [NPH-1:0] c_stb,
  input logic [NPH-1:0] f_stb
);

  a_r10_bus_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !((|c_stb) && (|f_stb)));

  a_r10_strobe_data: assert property (@(posedge clk) disable iff (!rst_n)
    ((c_stb & (c_ud ^ perr)) == '0) && ((f_stb & (f_ud ^ perr)) == '0));

  a_r4_mode_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !base_tick |=> ($stable(mode_q) && $stable(psw_q)));

  a_r5_regulated_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && psw_q[0]) |=> ((c_stb[NPH-1:1] == '0) && (f_stb[NPH-1:1] == '0)));

  a_r3_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_tick[NPH-1:1] == '0) |=> $stable(perr[NPH-1:1]));

endmodule

bind mp_err_sampler mp_err_sampler_chk #(.NPH(NPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .ph_tick(ph_tick),
  .mode_q(mode_q), .psw_q(psw_q), .perr(perr), .c_ud(c_ud), .f_ud(f_ud),
  .c_stb(c_stb), .f_stb(f_stb)
);

// File: tb/mp_err_sampler_bench.sv
module mp_err_sampler_bench;
  localparam int NPH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_tick = 1'b0;
  logic [NPH-1:0] ph_tick = '0;
  logic cmp_in = 1'b0;
  logic mode_in = 1'b0;
  logic [1:0] psw_in = 2'b00;
  logic [NPH-1:0] perr, c_ud, f_ud, c_stb, f_stb;

  always #4 clk = ~clk;

  mp_err_sampler #(.NPH(NPH)) u_mp_err_sampler (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .ph_tick(ph_tick),
    .cmp_in(cmp_in), .mode_in(mode_in), .psw_in(psw_in),
    .perr(perr), .c_ud(c_ud), .f_ud(f_ud), .c_stb(c_stb), .f_stb(f_stb)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string tag = "R1";

  int pipe[$];
  int m_mode = 0, m_psw = 0;
  bit [NPH-1:0] m_err = '0, m_cud = '0, m_fud = '0, m_cstb = '0, m_fstb = '0;

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s cyc=%0d actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic model_edge();
    bit reg_st, smp;
    bit [NPH-1:0] hit;
    reg_st = (m_mode == 0) && (m_psw % 2 == 1);
    smp = pipe[0][0];
    for (int k = 0; k < NPH; k++) begin
      if (k == 0) hit[k] = reg_st ? base_tick : ph_tick[0];
      else if (reg_st) hit[k] = 1'b0;
      else if ((k % 2 == 1) && (m_psw >= 2)) hit[k] = 1'b0;
      else hit[k] = ph_tick[k];
    end
    for (int k = 0; k < NPH; k++) begin
      m_cstb[k] = hit[k] && (m_mode == 1);
      m_fstb[k] = hit[k] && (m_mode == 0);
      if (hit[k]) begin
        m_err[k] = smp;
        if (m_mode == 1) m_cud[k] = smp; else m_fud[k] = smp;
      end
    end
    void'(pipe.pop_front());
    pipe.push_back(int'(cmp_in));
    if (base_tick) begin
      m_mode = int'(mode_in);
      m_psw = int'(psw_in);
    end
  endtask

  task automatic step(bit ph0_extra);
    int pos;
    pos = cyc % 8;
    base_tick = (pos == 0);
    for (int k = 0; k < NPH; k++) ph_tick[k] = (pos == 2 * k + 1);
    if (ph0_extra && pos == 4) ph_tick[0] = 1'b1;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, "perr R3", int'(perr), int'(m_err));
    check(tag, "c_ud R8", int'(c_ud), int'(m_cud));
    check(tag, "c_stb R8", int'(c_stb), int'(m_cstb));
    check(tag, "f_ud R9", int'(f_ud), int'(m_fud));
    check(tag, "f_stb R9", int'(f_stb), int'(m_fstb));
    cyc++;
    cmp_in = ($urandom % 3 == 0) ? ~cmp_in : cmp_in;
  endtask

  task automatic scene(string t, bit md, bit [1:0] ps, int len, bit extra);
    tag = t;
    mode_in = md;
    psw_in = ps;
    for (int i = 0; i < len; i++) step(extra);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(7));
    pipe = '{0, 0};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "perr", int'(perr), 0);
    check("R1", "c_ud", int'(c_ud), 0);
    check("R1", "f_ud", int'(f_ud), 0);
    check("R1", "strobes", int'(c_stb | f_stb), 0);
    rst_n = 1'b1;
    scene("R8", 1'b1, 2'b00, 43, 1'b0);
    scene("R9", 1'b0, 2'b00, 37, 1'b0);
    scene("R4", 1'b1, 2'b01, 5, 1'b0);
    scene("R5", 1'b0, 2'b01, 45, 1'b0);
    scene("R6", 1'b0, 2'b01, 40, 1'b1);
    scene("R7", 1'b1, 2'b10, 35, 1'b0);
    scene("R7", 1'b0, 2'b10, 29, 1'b0);
    scene("R4", 1'b0, 2'b11, 3, 1'b0);
    scene("R10", 1'b1, 2'b01, 33, 1'b0);
    tag = "R2";
    cmp_in = 1'b1;
    mode_in = 1'b1;
    psw_in = 2'b00;
    for (int i = 0; i < 60; i++) begin
      if (i % 11 == 0) cmp_in = ~cmp_in;
      step(1'b0);
    end
    summary();
  end
endmodule